// File: doc/BRIEF.md
# Dual-Mode Double-Buffered DAC Input Register

This block is the digital front end of a 16-bit digital-to-analog converter. It gathers a code word into a first-rank holding register and transfers it to a second-rank DAC register, whose contents drive the converter. A mode pin selects how the word arrives. In serial mode, one data pin supplies one bit for each rising edge of chip select, and the shift direction can be chosen. In byte mode, an 8-bit bus is written into the upper or lower half of the word under two level-sensitive enables, in either order.

A level-sensitive load input copies the holding register into the DAC register. A clear input forces the DAC register to zero and leaves the holding register alone, so the word it holds can be loaded again later. The clear target is either unipolar zero or bipolar (midscale) zero, chosen by the level of the low-byte enable. In serial mode the bit pushed out of the holding register appears on a serial output, so several devices can be chained. Every pin input passes through a two-stage synchroniser on the system clock. A change at a pin therefore acts on the third rising clock edge after it, and each phase of chip select must last at least two clocks.

Top module: `dac_input_register`

## Requirements
- R1: After reset, the DAC code and the holding register are both 0x0000, and the serial output is 0.
- R2: With the mode pin low and data bit 1 high (MSB first), each chip-select rising edge shifts the holding register up by one and puts data bit 0 into bit 0. After 16 edges, the first bit sent is in bit 15.
- R3: With the mode pin low and data bit 1 low (LSB first), each chip-select rising edge shifts the holding register down by one and puts data bit 0 into bit 15. After 16 edges, the first bit sent is in bit 0.
- R4: On every serial shift, the serial output takes the bit that leaves the register: old bit 15 in MSB-first order, old bit 0 in LSB-first order. Otherwise it holds its value.
- R5: With the mode pin high, while the high enable is high the bus is written into bits 15:8, and while the low enable is high it is written into bits 7:0. The two halves may be written in either order.
- R6: While load is high and clear is low, the DAC code takes the holding register value one clock after each synchronised sample. While load and clear are both low, the DAC code holds.
- R7: While clear is high, the DAC code becomes 0x0000 if the low enable is low and 0x8000 if it is high. Clear takes priority over load.
- R8: Clear does not alter the holding register. Raising load after a clear restores the word that was held before.
- R9: In serial mode the high enable and bus bits 7:2 have no effect on the holding register. In byte mode, chip-select edges have no effect on the holding register.
- R10: A pin change takes effect at the third rising clock edge after it is applied, never sooner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_mode | input | 1 | 1 selects byte loading, 0 selects serial loading |
| data_in | input | 8 | Byte bus; in serial mode bit 0 is the serial data and bit 1 is the order select (1 = MSB first) |
| cs | input | 1 | Chip select; its rising edge shifts one serial bit |
| hi_en | input | 1 | Upper-half write enable (byte mode) |
| lo_en | input | 1 | Lower-half write enable (byte mode) and clear-target select |
| load | input | 1 | Level-sensitive transfer from holding register to DAC register |
| clr | input | 1 | Clear of the DAC register |
| ser_out | output | 1 | Bit shifted out of the holding register, for chaining |
| dac_code | output | 16 | DAC register contents |

## Verification
Load, clear and a serial shift can all occur on the same clock edge. When load and clear are raised together, clear must win. When a chip-select rising edge lines up with an active load, the DAC register must take the holding-register value from before the shift. The bench drives these overlaps on purpose and compares every output on every clock against a behavioural model that applies the delayed pin samples in that order of priority.

// File: rtl/dac_input_register.sv
`timescale 1ns/1ps
module dac_input_register #(
  parameter int BYTE_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  byte_mode,
  input  logic [BYTE_W-1:0]     data_in,
  input  logic                  cs,
  input  logic                  hi_en,
  input  logic                  lo_en,
  input  logic                  load,
  input  logic                  clr,
  output logic                  ser_out,
  output logic [2*BYTE_W-1:0]   dac_code
);
  localparam int DW = 2 * BYTE_W;
  localparam int PW = BYTE_W + 6;
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  logic [PW-1:0] sync_q [SYNC_N];
  logic [PW-1:0] pins_s;
  logic [BYTE_W-1:0] bus_s;
  logic mode_s, cs_s, hi_s, lo_s, load_s, clr_s;
  logic cs_prev, cs_rise, shift_now, order_s;
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_N; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {clr, load, lo_en, hi_en, cs, byte_mode, data_in};
      for (int i = 1; i < SYNC_N; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign pins_s = sync_q[SYNC_N-1];
  assign {clr_s, load_s, lo_s, hi_s, cs_s, mode_s, bus_s} = pins_s;
  assign order_s   = bus_s[1];
  assign cs_rise   = cs_s & ~cs_prev;
  assign shift_now = cs_rise & ~mode_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_prev <= 1'b0;
    else        cs_prev <= cs_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      ser_out <= 1'b0;
    end else if (shift_now) begin
      if (order_s) begin
        hold_q  <= {hold_q[DW-2:0], bus_s[0]};
        ser_out <= hold_q[DW-1];
      end else begin
        hold_q  <= {bus_s[0], hold_q[DW-1:1]};
        ser_out <= hold_q[0];
      end
    end else if (mode_s) begin
      if (hi_s) hold_q[DW-1:BYTE_W] <= bus_s;
      if (lo_s) hold_q[BYTE_W-1:0]  <= bus_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dac_code <= '0;
    else if (clr_s)  dac_code <= lo_s ? MID : '0;
    else if (load_s) dac_code <= hold_q;
  end

  // R7
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> (dac_code == '0 || dac_code == MID));

  // R6
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && !load_s) |=> $stable(dac_code));

  // R6
  dac_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_s && !clr_s) |=> dac_code == $past(hold_q));

  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_rise && !hi_s && !lo_s) |=> $stable(hold_q));

  // R4
  sout_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_now && order_s) |=> ser_out == $past(hold_q[DW-1]));

  // R4
  sout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_now |=> $stable(ser_out));
endmodule

// File: tb/test_dac_input_register.sv
`timescale 1ns/1ps
module test_dac_input_register;
  logic clk = 0, rst_n = 0;
  logic byte_mode = 0, cs = 1, hi_en = 0, lo_en = 0, load = 0, clr = 0;
  logic [7:0] data_in = 0;
  logic ser_out;
  logic [15:0] dac_code;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dac_input_register i_dac_input_register (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .data_in(data_in),
    .cs(cs), .hi_en(hi_en), .lo_en(lo_en), .load(load), .clr(clr),
    .ser_out(ser_out), .dac_code(dac_code));

  logic [13:0] hist [$];
  logic [13:0] v;
  logic [15:0] m_hold, m_dac, nh, nd;
  logic m_sout = 0, m_prev = 0;
  initial begin m_hold = 0; m_dac = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete(); m_hold = 0; m_dac = 0; m_sout = 0; m_prev = 0;
    end else begin
      hist.push_back({clr, load, lo_en, hi_en, cs, byte_mode, data_in});
      if (hist.size() > 2) begin
        v = hist.pop_front();
        nd = m_dac;
        if (v[13]) nd = v[11] ? 16'h8000 : 16'h0000;
        else if (v[12]) nd = m_hold;
        nh = m_hold;
        if (!v[8] && v[9] && !m_prev) begin
          if (v[1]) begin m_sout = m_hold[15]; nh = {m_hold[14:0], v[0]}; end
          else      begin m_sout = m_hold[0];  nh = {v[0], m_hold[15:1]}; end
        end else if (v[8]) begin
          if (v[10]) nh[15:8] = v[7:0];
          if (v[11]) nh[7:0]  = v[7:0];
        end
        m_prev = v[9];
        m_hold = nh; m_dac = nd;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (dac_code !== m_dac) begin
        errors++;
        $display("FAIL R6/R7 model dac_code: actual %h expected %h at %0t", dac_code, m_dac, $time);
      end
      checks++;
      if (ser_out !== m_sout) begin
        errors++;
        $display("FAIL R4 model ser_out: actual %b expected %b at %0t", ser_out, m_sout, $time);
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  logic [15:0] outbits;

  task automatic send_serial(input logic [15:0] w, input bit msb_first);
    for (int i = 0; i < 16; i++) begin
      data_in = {6'b101101, msb_first, msb_first ? w[15-i] : w[i]};
      cs = 0; wait_n(3);
      cs = 1; wait_n(3);
      outbits = {outbits[14:0], ser_out};
    end
  endtask

  task automatic pulse_load();
    load = 1; wait_n(4); load = 0; wait_n(4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    // R1
    chk("R1 dac reset", dac_code, 16'h0000);
    chk("R1 sout reset", {15'd0, ser_out}, 16'h0000);

    // R2 MSB-first assembly; R6 hold before load
    send_serial(16'hA5C3, 1);
    chk("R6 hold without load", dac_code, 16'h0000);
    pulse_load();
    chk("R2 msb first word", dac_code, 16'hA5C3);

    // R4 chained shift-out
    outbits = 0;
    send_serial(16'h0F0F, 1);
    chk("R4 shifted-out bits", outbits, 16'hA5C3);
    pulse_load();
    chk("R2 second msb word", dac_code, 16'h0F0F);

    // R3 LSB-first assembly
    send_serial(16'h1234, 0);
    pulse_load();
    chk("R3 lsb first word", dac_code, 16'h1234);

    // R9 serial mode ignores hi_en and upper bus bits
    hi_en = 1; data_in = 8'hFC; wait_n(6); hi_en = 0; wait_n(3);
    pulse_load();
    chk("R9 serial ignores hi_en", dac_code, 16'h1234);

    // R7 clear to bipolar zero, R8 holding register kept
    lo_en = 1; clr = 1; wait_n(4); clr = 0; wait_n(3);
    chk("R7 clear bipolar", dac_code, 16'h8000);
    lo_en = 0; wait_n(3);
    pulse_load();
    chk("R8 reload after clear", dac_code, 16'h1234);

    // R7 clear and load together, unipolar target
    clr = 1; load = 1; wait_n(4);
    chk("R7 clear beats load", dac_code, 16'h0000);
    clr = 0; wait_n(4); load = 0; wait_n(3);
    chk("R8 load after overlap", dac_code, 16'h1234);

    // R10 latency of load
    clr = 1; wait_n(4); clr = 0; wait_n(3);
    load = 1;
    wait_n(2);
    chk("R10 no effect after two edges", dac_code, 16'h0000);
    wait_n(1);
    chk("R10 effect at third edge", dac_code, 16'h1234);
    load = 0; wait_n(3);

    // R5 byte mode, low half first then high
    byte_mode = 1; wait_n(3);
    data_in = 8'hEF; lo_en = 1; wait_n(3); lo_en = 0;
    data_in = 8'hBE; hi_en = 1; wait_n(3); hi_en = 0; wait_n(3);
    pulse_load();
    chk("R5 low then high", dac_code, 16'hBEEF);

    // R5 high half first then low
    data_in = 8'h5A; hi_en = 1; wait_n(3); hi_en = 0;
    data_in = 8'h69; lo_en = 1; wait_n(3); lo_en = 0; wait_n(3);
    pulse_load();
    chk("R5 high then low", dac_code, 16'h5A69);

    // R9 byte mode ignores chip-select edges
    for (int k = 0; k < 4; k++) begin
      data_in = 8'h03; cs = 0; wait_n(3); cs = 1; wait_n(3);
    end
    pulse_load();
    chk("R9 byte mode ignores cs", dac_code, 16'h5A69);

    // shift edge and load in the same cycle (model compares each clock)
    byte_mode = 0; wait_n(3);
    data_in = 8'h03; cs = 0; wait_n(3);
    load = 1; cs = 1; wait_n(4); load = 0; wait_n(3);
    chk("R6 load after overlap shift", dac_code, 16'hB4D3);

    wait_n(5);
    finish_run();
  end
endmodule